// File: doc/BRIEF.md
# One-Wire Bus Slot Timing Engine

This block is the timing core of a master for a single-wire, open-drain serial bus. It produces one bus time slot per command: a reset with presence detection, a write-0 slot, a write-1 slot, a read slot, or a combined touch slot. Each slot is a low phase, a released phase and an optional tail. The engine pulls the line low through an active-low pull-down enable and otherwise leaves the level to an external pull-up. It samples the line once per read or reset slot, at a fixed offset.

All durations are counted in microseconds. A divider derives the microsecond tick from the system clock using the parameter `CLKS_PER_US`. A runtime stretch factor, captured when a command is accepted, multiplies every duration. A caller issues a one-cycle command while `busy` is low and waits for the one-cycle `done` pulse. It then reads `rx_bit` or `presence_n`. Sequencing of bytes and higher-level bus commands belongs to the logic around this block.

Top module: `owb_slot_engine`

## Requirements
- R1: A write-1 slot (`cmd_op`=2'b01, `cmd_bit`=1) pulls the line low for 6 µs and then releases it for 64 µs before completing.
- R2: A write-0 slot (`cmd_op`=2'b01, `cmd_bit`=0) pulls the line low for 60 µs and then releases it for 10 µs before completing.
- R3: A read slot (`cmd_op`=2'b10) pulls low for 6 µs and releases for 9 µs. It stores the line level sampled at the 15 µs point into `rx_bit`, then waits 55 µs more before completing.
- R4: A reset slot (`cmd_op`=2'b00) pulls low for 500 µs and releases for 70 µs. It stores the line level sampled at that point into `presence_n` (0 = a device answered, 1 = none), then idles 1000 µs before completing.
- R5: Every duration is multiplied by the `stretch` value captured at acceptance; a value of 0 acts as 1, and later changes to `stretch` do not affect a running slot.
- R6: A touch command (`cmd_op`=2'b11) with `cmd_bit`=1 runs a read slot and returns the sample in `rx_bit`. With `cmd_bit`=0 it runs a write-0 slot and sets `rx_bit` to 0.
- R7: A command is accepted only on a cycle where `busy` is low; `cmd_valid` while `busy` is high is ignored and leaves the running slot's timing and results unchanged.
- R8: `done` is high for exactly one cycle, the first cycle with `busy` low after a slot. A command presented in that cycle is accepted.
- R9: `bus_pull_n` is low only during a slot's low phase and is high whenever the engine is idle.
- R10: After reset `busy`=0, `done`=0, `bus_pull_n`=1, `rx_bit`=0 and `presence_n`=1.
- R11: Write slots leave `rx_bit` unchanged. Only reset slots change `presence_n`. Neither output changes while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Slot kind: 00 reset, 01 write, 10 read, 11 touch |
| cmd_bit | input | 1 | Data bit for write and touch |
| stretch | input | STRETCH_W | Duration multiplier, 0 treated as 1 |
| bus_in | input | 1 | Sampled level of the bus line |
| bus_pull_n | output | 1 | Active-low pull-down enable for the line |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Last read or touch result |
| presence_n | output | 1 | Last presence result, 0 when a device answered |

## Verification
Two things can land in the same cycle: the `done` pulse of one slot and the acceptance of the next command. The bench provokes this on every slot of its sweep by issuing the next command in the very cycle `done` is seen. It judges acceptance from the length of the following slot's low phase and busy period, and checks that `done` dropped. A second collision is a command strobe, together with a changed stretch value, arriving partway through a write-0 slot. It is judged by the low time, busy time and results being exactly those of the undisturbed slot. The sample instant is pinned by a line model that shows the device's answer only in the single cycle before the sampling edge.

// File: rtl/owb_pkg.sv
package owb_pkg;

  localparam int UNIT_W = 11;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_TOUCH = 2'b11
  } owb_op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_REL,
    PH_TAIL
  } owb_phase_e;

  typedef struct packed {
    logic [UNIT_W-1:0] lo_us;
    logic [UNIT_W-1:0] rel_us;
    logic [UNIT_W-1:0] tail_us;
    logic              grab_pres;
    logic              grab_data;
    logic              zero_data;
  } owb_slot_t;

  localparam int RST_LOW_US  = 500;
  localparam int RST_REL_US  = 70;
  localparam int RST_IDLE_US = 1000;
  localparam int ONE_LOW_US  = 6;
  localparam int ONE_REL_US  = 64;
  localparam int ZERO_LOW_US = 60;
  localparam int ZERO_REL_US = 10;
  localparam int RD_LOW_US   = 6;
  localparam int RD_REL_US   = 9;
  localparam int RD_TAIL_US  = 55;

  function automatic owb_slot_t mk_slot(input int lo, input int rel, input int tail,
                                        input logic gp, input logic gd, input logic zd);
    owb_slot_t s;
    s.lo_us     = UNIT_W'(lo);
    s.rel_us    = UNIT_W'(rel);
    s.tail_us   = UNIT_W'(tail);
    s.grab_pres = gp;
    s.grab_data = gd;
    s.zero_data = zd;
    return s;
  endfunction

  function automatic owb_slot_t slot_for(input owb_op_e op, input logic b);
    owb_slot_t s;
    case (op)
      OP_RESET: s = mk_slot(RST_LOW_US, RST_REL_US, RST_IDLE_US, 1'b1, 1'b0, 1'b0);
      OP_WRITE: s = b ? mk_slot(ONE_LOW_US, ONE_REL_US, 0, 1'b0, 1'b0, 1'b0)
                      : mk_slot(ZERO_LOW_US, ZERO_REL_US, 0, 1'b0, 1'b0, 1'b0);
      OP_READ:  s = mk_slot(RD_LOW_US, RD_REL_US, RD_TAIL_US, 1'b0, 1'b1, 1'b0);
      OP_TOUCH: s = b ? mk_slot(RD_LOW_US, RD_REL_US, RD_TAIL_US, 1'b0, 1'b1, 1'b0)
                      : mk_slot(ZERO_LOW_US, ZERO_REL_US, 0, 1'b0, 1'b0, 1'b1);
      default:  s = mk_slot(RD_LOW_US, RD_REL_US, RD_TAIL_US, 1'b0, 1'b1, 1'b0);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/owb_rst_sync.sv
module owb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/owb_tick_div.sv
module owb_tick_div #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] last,
  output logic             pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pulse = en && (cnt_q == last);
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = pulse ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/owb_slot_fsm.sv
module owb_slot_fsm
  import owb_pkg::*;
#(
  parameter int STRETCH_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic                 cmd_bit,
  input  logic [STRETCH_W-1:0] stretch,
  input  logic                 unit_tick,
  input  logic                 bus_in,
  output logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 rx_bit,
  output logic                 presence_n,
  output logic                 bus_pull_n,
  output logic [STRETCH_W-1:0] stretch_last
);

  owb_phase_e            ph_q, ph_d;
  logic [UNIT_W-1:0]     cnt_q, cnt_d;
  owb_slot_t             slot_q, slot_d;
  logic [STRETCH_W-1:0]  sl_q, sl_d;
  logic                  done_q, done_d;
  logic                  rx_q, rx_d;
  logic                  pres_q, pres_d;
  logic [UNIT_W-1:0]     ph_len;
  logic                  ph_end;

  always_comb begin
    case (ph_q)
      PH_LOW:  ph_len = slot_q.lo_us;
      PH_REL:  ph_len = slot_q.rel_us;
      PH_TAIL: ph_len = slot_q.tail_us;
      default: ph_len = '0;
    endcase
  end

  assign busy   = (ph_q != PH_IDLE);
  assign start  = cmd_valid && !busy;
  assign ph_end = unit_tick && (cnt_q == ph_len - UNIT_W'(1));

  // next-state process
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    sl_d   = sl_q;
    done_d = 1'b0;
    rx_d   = rx_q;
    pres_d = pres_q;

    if (busy && unit_tick) cnt_d = ph_end ? '0 : cnt_q + UNIT_W'(1);

    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          slot_d = slot_for(owb_op_e'(cmd_op), cmd_bit);
          sl_d   = (stretch == '0) ? '0 : stretch - STRETCH_W'(1);
          cnt_d  = '0;
          ph_d   = PH_LOW;
        end
      end
      PH_LOW: begin
        if (ph_end) ph_d = PH_REL;
      end
      PH_REL: begin
        if (ph_end) begin
          if (slot_q.grab_pres) pres_d = bus_in;
          if (slot_q.grab_data) rx_d   = bus_in;
          if (slot_q.zero_data) rx_d   = 1'b0;
          if (slot_q.tail_us == '0) begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end else begin
            ph_d = PH_TAIL;
          end
        end
      end
      PH_TAIL: begin
        if (ph_end) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      slot_q <= '0;
      sl_q   <= '0;
      done_q <= 1'b0;
      rx_q   <= 1'b0;
      pres_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      sl_q   <= sl_d;
      done_q <= done_d;
      rx_q   <= rx_d;
      pres_q <= pres_d;
    end
  end

  assign done         = done_q;
  assign rx_bit       = rx_q;
  assign presence_n   = pres_q;
  assign bus_pull_n   = (ph_q != PH_LOW);
  assign stretch_last = sl_q;

endmodule

// File: rtl/owb_slot_engine.sv
module owb_slot_engine #(
  parameter int CLKS_PER_US = 100,
  parameter int STRETCH_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic                 cmd_bit,
  input  logic [STRETCH_W-1:0] stretch,
  input  logic                 bus_in,
  output logic                 bus_pull_n,
  output logic                 busy,
  output logic                 done,
  output logic                 rx_bit,
  output logic                 presence_n
);

  localparam int              US_W    = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [US_W-1:0] US_LAST = US_W'(CLKS_PER_US - 1);

  logic                 rst_n_sync;
  logic                 start;
  logic                 us_tick;
  logic                 unit_tick;
  logic [STRETCH_W-1:0] stretch_last;

  owb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  owb_tick_div #(.CNT_W(US_W)) u_us_div (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (start),
    .en    (busy),
    .last  (US_LAST),
    .pulse (us_tick)
  );

  owb_tick_div #(.CNT_W(STRETCH_W)) u_stretch_div (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (start),
    .en    (us_tick),
    .last  (stretch_last),
    .pulse (unit_tick)
  );

  owb_slot_fsm #(.STRETCH_W(STRETCH_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_bit      (cmd_bit),
    .stretch      (stretch),
    .unit_tick    (unit_tick),
    .bus_in       (bus_in),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .rx_bit       (rx_bit),
    .presence_n   (presence_n),
    .bus_pull_n   (bus_pull_n),
    .stretch_last (stretch_last)
  );

endmodule

// File: rtl/owb_slot_chk.sv
module owb_slot_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic bus_pull_n,
  input logic rx_bit,
  input logic presence_n
);

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);  // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));  // R8

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_pull_n);  // R9

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(rx_bit) && $stable(presence_n)));  // R11

endmodule

bind owb_slot_engine owb_slot_chk u_chk (.*);

// File: tb/owb_slot_engine_tb.sv
module owb_slot_engine_tb;

  localparam int CPU = 2;
  localparam int SW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic          cmd_bit = 1'b0;
  logic [SW-1:0] stretch = 3'd1;
  logic          bus_in;
  logic          bus_pull_n, busy, done, rx_bit, presence_n;

  int   cyc = 0;
  int   t0 = 0;
  int   kmark = -1;
  logic resp_g = 1'b1;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic mod_rx = 1'b0;
  logic mod_pres = 1'b1;

  owb_slot_engine #(.CLKS_PER_US(CPU), .STRETCH_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .stretch(stretch), .bus_in(bus_in),
    .bus_pull_n(bus_pull_n), .busy(busy), .done(done),
    .rx_bit(rx_bit), .presence_n(presence_n)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // line model: device answer visible only in the cycle just before the sampling edge
  assign bus_in = !bus_pull_n ? 1'b0 : (((cyc - t0) == kmark) ? resp_g : ~resp_g);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_slot(input logic [1:0] op, input logic b, input int sv, input logic resp,
                          input int lo, input int rel, input int tail, input string req,
                          input bit poke);
    int s, lo_n, busy_n, last_low, rc;
    bit done_early;
    s = (sv == 0) ? 1 : sv;
    resp_g = resp;
    kmark = (lo + rel) * s * CPU;
    t0 = cyc;
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b; stretch = SW'(sv);
    @(negedge clk);
    cmd_valid = 1'b0;
    lo_n = 0; busy_n = 0; last_low = 0; done_early = 0;
    while (busy) begin
      rc = cyc - t0;
      busy_n++;
      if (!bus_pull_n) begin lo_n++; last_low = rc; end
      if (done) done_early = 1;
      if (poke && rc == 3) begin cmd_valid = 1'b1; cmd_op = 2'b00; stretch = 3'd7; end
      else if (poke && rc == 4) cmd_valid = 1'b0;
      @(negedge clk);
    end
    chk(lo_n == lo * s * CPU, {req, " low cycles"}, lo_n, lo * s * CPU);
    chk(last_low == lo * s * CPU, {req, " low phase position"}, last_low, lo * s * CPU);
    chk(busy_n == (lo + rel + tail) * s * CPU, {req, " busy cycles"}, busy_n, (lo + rel + tail) * s * CPU);
    chk(done == 1'b1 && !done_early, {req, " R8 done pulse"}, done, 1);
    chk(rx_bit == mod_rx, {req, " rx_bit"}, rx_bit, mod_rx);
    chk(presence_n == mod_pres, {req, " presence_n"}, presence_n, mod_pres);
    kmark = -1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R10 busy/done in reset", {busy, done}, 0);
    chk(bus_pull_n == 1, "R10 line released in reset", bus_pull_n, 1);
    chk(rx_bit == 0 && presence_n == 1, "R10 results in reset", {rx_bit, presence_n}, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_pull_n == 1 && busy == 0, "R9 idle line released", bus_pull_n, 1);

    // R4 reset slots, presence both ways, R5 zero stretch acts as one
    mod_pres = 1'b1; run_slot(2'b00, 1'b0, 1, 1'b1, 500, 70, 1000, "R4 reset no device s=1", 0);
    mod_pres = 1'b0; run_slot(2'b00, 1'b0, 0, 1'b0, 500, 70, 1000, "R4 R5 reset device s=0", 0);
    mod_pres = 1'b1; run_slot(2'b00, 1'b0, 2, 1'b1, 500, 70, 1000, "R4 R5 reset s=2", 0);
    mod_pres = 1'b0; run_slot(2'b00, 1'b0, 3, 1'b0, 500, 70, 1000, "R4 R5 reset s=3", 0);

    for (int sv = 0; sv < 8; sv++) begin
      mod_rx = 1'b1; run_slot(2'b10, 1'b0, sv, 1'b1, 6, 9, 55, "R3 R5 read high", 0);
      run_slot(2'b01, 1'b1, sv, 1'b0, 6, 64, 0, "R1 R11 write-1", 0);
      run_slot(2'b01, 1'b0, sv, 1'b0, 60, 10, 0, "R2 R11 write-0", 0);
      mod_rx = 1'b0; run_slot(2'b10, 1'b0, sv, 1'b0, 6, 9, 55, "R3 R5 read low", 0);
      mod_rx = 1'b1; run_slot(2'b11, 1'b1, sv, 1'b1, 6, 9, 55, "R6 touch-1 high", 0);
      mod_rx = 1'b0; run_slot(2'b11, 1'b0, sv, 1'b1, 60, 10, 0, "R6 touch-0 clears", 0);
      mod_rx = 1'b0; run_slot(2'b11, 1'b1, sv, 1'b0, 6, 9, 55, "R6 touch-1 low", 0);
    end

    // R7 command while busy ignored; R5 stretch latched at acceptance
    run_slot(2'b01, 1'b0, 2, 1'b0, 60, 10, 0, "R7 R5 busy command ignored", 1);
    stretch = 3'd1;

    @(negedge clk);
    chk(done == 0, "R8 done drops after one cycle", done, 0);
    chk(busy == 0 && bus_pull_n == 1, "R7 R9 no stray slot started", {busy, bus_pull_n}, 1);
    repeat (3) @(negedge clk);
    chk(rx_bit == mod_rx && presence_n == mod_pres, "R11 results held in idle",
        {rx_bit, presence_n}, {mod_rx, mod_pres});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule